// File: doc/BRIEF.md
# Handshake Averaging Filter Controller

This block is a streaming two-tap filter with four-phase handshake channels on both sides. Each transaction takes a sample `x` from the input channel and offers `floor((x + y) / 2)` on the output channel. Once the output channel has consumed that result, the block copies `x` into its history register `y`. `y` is zero after reset, so the first result is `x / 2`.

Inside the block, the x store, the y store, the adder and the output store each run their own request/acknowledge pair. A clocked sequencer drives these pairs in a fixed order. A phase bit marks whether the output of the current transaction has been consumed yet. The input acknowledge is raised only after the y store has been refreshed and every internal request has returned to zero. A slow consumer therefore stalls the producer. The adder takes a parameterised number of cycles, which stands in for a matched delay.

Top module: `hs_avg_filter`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `in_ack`, `out_req` and `out_data` are all 0, and the history value is 0.
- R2: When `out_req` rises, `out_data` equals `(x + y) >> 1`. Here `x` is the `in_data` accepted in the same transaction, and the sum is formed at DATA_W+1 bits with the remainder dropped.
- R3: `y` takes the value of `x` only after the output handshake of that transaction has completed. The next transaction averages against that `x`, and the first one after reset averages against 0.
- R4: From the cycle `out_req` rises until `out_ack` is seen high, `out_data` does not change.
- R5: `in_ack` rises only after the output handshake of the same transaction has fully returned to zero. While the consumer withholds `out_ack`, `in_ack` stays 0.
- R6: `out_req` rises only while `out_ack` is 0, and it falls only after `out_ack` is 1.
- R7: `in_ack` falls only after `in_req` is 0. A new transaction starts only once `in_ack` is back at 0.
- R8: All-ones operands give an all-ones result, with no wrap of the sum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_req | input | 1 | Input channel request: `in_data` is valid |
| in_data | input | DATA_W | Input sample |
| in_ack | output | 1 | Input channel acknowledge |
| out_req | output | 1 | Output channel request: `out_data` is valid |
| out_data | output | DATA_W | Averaged result |
| out_ack | input | 1 | Output channel acknowledge |

## Verification
The hardest state to reach from the ports is a transaction whose output has been offered but not consumed while the producer is still holding its request. This is where an early input acknowledge or an early history update would show up. The bench gets there with a consumer whose acknowledge delay varies, including one very long stall, while it watches that `in_ack` stays low. Back-to-back equal all-ones samples and zero samples check the widened sum and the history carried between transactions.

// File: rtl/avg_filter_pkg.sv
`timescale 1ns/1ps
package avg_filter_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_X_OPEN,
        ST_ADD,
        ST_O_LOAD,
        ST_O_CLOSE,
        ST_O_REQ,
        ST_O_RET,
        ST_Y_OPEN,
        ST_CLOSE,
        ST_RELEASE
    } seq_state_e;

    typedef struct packed {
        seq_state_e st;
        logic       z;     // phase: output consumed
        logic       rx;
        logic       ry;
        logic       ra;
        logic       rl;
        logic       rout;
        logic       ain;
    } seq_regs_t;

endpackage

// File: rtl/avg_store_latch.sv
`timescale 1ns/1ps
module avg_store_latch #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic [DATA_W-1:0] din,
    output logic              ack,
    output logic [DATA_W-1:0] dout
);

    typedef struct packed {
        logic              ack;
        logic [DATA_W-1:0] data;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.ack = req;
        if (req) begin
            st_d.data = din;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ack  = st_q.ack;
    assign dout = st_q.data;

    AST_STORE_OPAQUE: assert property (@(posedge clk) disable iff (!rst_n)
        (!req && !ack) |=> $stable(dout)); // R3

endmodule

// File: rtl/avg_half_adder.sv
`timescale 1ns/1ps
module avg_half_adder #(
    parameter int DATA_W  = 8,
    parameter int ADD_LAT = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic              ack,
    output logic [DATA_W-1:0] avg
);

    localparam int CNT_W = (ADD_LAT < 2) ? 1 : $clog2(ADD_LAT + 1);
    localparam int SUM_W = DATA_W + 1;

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic              ack;
        logic [DATA_W-1:0] avg;
    } add_t;

    add_t             ad_d, ad_q;
    logic [SUM_W-1:0] sum_w;

    assign sum_w = {1'b0, a} + {1'b0, b};

    always_comb begin
        ad_d = ad_q;
        if (!req) begin
            ad_d.cnt = '0;
            ad_d.ack = 1'b0;
        end else if (!ad_q.ack) begin
            if (ad_q.cnt == CNT_W'(ADD_LAT - 1)) begin
                ad_d.ack = 1'b1;
                ad_d.avg = sum_w[SUM_W-1:1];
            end else begin
                ad_d.cnt = ad_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ad_q <= '0;
        end else begin
            ad_q <= ad_d;
        end
    end

    assign ack = ad_q.ack;
    assign avg = ad_q.avg;

    AST_ADD_ACK_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack) |-> $past(req)); // R2

    AST_ADD_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && $past(ack)) |-> $stable(avg)); // R4

endmodule

// File: rtl/avg_seq_ctrl.sv
`timescale 1ns/1ps
module avg_seq_ctrl
    import avg_filter_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic in_req,
    output logic in_ack,
    output logic out_req,
    input  logic out_ack,
    output logic rx,
    input  logic ax,
    output logic ry,
    input  logic ay,
    output logic ra,
    input  logic aa,
    output logic rl,
    input  logic al
);

    seq_regs_t sq_d, sq_q;

    always_comb begin
        sq_d = sq_q;
        unique case (sq_q.st)
            ST_IDLE: if (in_req && !sq_q.ain) begin
                sq_d.rx = 1'b1;
                sq_d.st = ST_X_OPEN;
            end
            ST_X_OPEN: if (ax) begin
                sq_d.ra = 1'b1;
                sq_d.st = ST_ADD;
            end
            ST_ADD: if (aa) begin
                sq_d.rl = 1'b1;
                sq_d.st = ST_O_LOAD;
            end
            ST_O_LOAD: if (al) begin
                sq_d.rl = 1'b0;
                sq_d.st = ST_O_CLOSE;
            end
            ST_O_CLOSE: if (!al && !out_ack) begin
                sq_d.rout = 1'b1;
                sq_d.st   = ST_O_REQ;
            end
            ST_O_REQ: if (out_ack) begin
                sq_d.rout = 1'b0;
                sq_d.z    = 1'b1;
                sq_d.st   = ST_O_RET;
            end
            ST_O_RET: if (!out_ack) begin
                sq_d.ry = 1'b1;
                sq_d.st = ST_Y_OPEN;
            end
            ST_Y_OPEN: if (ay) begin
                sq_d.ry = 1'b0;
                sq_d.rx = 1'b0;
                sq_d.st = ST_CLOSE;
            end
            ST_CLOSE: if (!ay && !ax) begin
                sq_d.ain = 1'b1;
                sq_d.ra  = 1'b0;
                sq_d.st  = ST_RELEASE;
            end
            ST_RELEASE: if (!in_req && !aa) begin
                sq_d.ain = 1'b0;
                sq_d.z   = 1'b0;
                sq_d.st  = ST_IDLE;
            end
            default: sq_d = '{st: ST_IDLE, default: 1'b0};
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sq_q <= '{st: ST_IDLE, default: 1'b0};
        end else begin
            sq_q <= sq_d;
        end
    end

    assign in_ack  = sq_q.ain;
    assign out_req = sq_q.rout;
    assign rx      = sq_q.rx;
    assign ry      = sq_q.ry;
    assign ra      = sq_q.ra;
    assign rl      = sq_q.rl;

    AST_Y_AFTER_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ry) |-> (sq_q.z && !out_req && !out_ack)); // R3

    AST_IN_ACK_LATE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_ack) |-> (!out_req && !out_ack && !ay && !ax)); // R5

    AST_OUT_RISE_LOW_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_req) |-> $past(!out_ack)); // R6

    AST_OUT_FALL_HIGH_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(out_req) |-> $past(out_ack)); // R6

    AST_IN_ACK_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(in_ack) |-> $past(!in_req)); // R7

    AST_ONE_REQ_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        !(rl && out_req)); // R4

endmodule

// File: rtl/hs_avg_filter.sv
`timescale 1ns/1ps
module hs_avg_filter #(
    parameter int DATA_W  = 8,
    parameter int ADD_LAT = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_req,
    input  logic [DATA_W-1:0] in_data,
    output logic              in_ack,
    output logic              out_req,
    output logic [DATA_W-1:0] out_data,
    input  logic              out_ack
);

    logic              rx, ax, ry, ay, ra, aa, rl, al;
    logic [DATA_W-1:0] x_val, y_val, avg_val;

    avg_seq_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_req  (in_req),
        .in_ack  (in_ack),
        .out_req (out_req),
        .out_ack (out_ack),
        .rx      (rx),
        .ax      (ax),
        .ry      (ry),
        .ay      (ay),
        .ra      (ra),
        .aa      (aa),
        .rl      (rl),
        .al      (al)
    );

    avg_store_latch #(.DATA_W(DATA_W)) u_x_store (
        .clk (clk), .rst_n (rst_n), .req (rx), .din (in_data),
        .ack (ax), .dout (x_val)
    );

    avg_store_latch #(.DATA_W(DATA_W)) u_y_store (
        .clk (clk), .rst_n (rst_n), .req (ry), .din (x_val),
        .ack (ay), .dout (y_val)
    );

    avg_half_adder #(.DATA_W(DATA_W), .ADD_LAT(ADD_LAT)) u_adder (
        .clk (clk), .rst_n (rst_n), .req (ra), .a (x_val), .b (y_val),
        .ack (aa), .avg (avg_val)
    );

    avg_store_latch #(.DATA_W(DATA_W)) u_o_store (
        .clk (clk), .rst_n (rst_n), .req (rl), .din (avg_val),
        .ack (al), .dout (out_data)
    );

    AST_OUT_DATA_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (out_req && $past(out_req) && !$past(out_ack)) |-> $stable(out_data)); // R4

    AST_Y_ONLY_LATE: assert property (@(posedge clk) disable iff (!rst_n)
        (out_req || in_ack) |=> $stable(y_val) || !$past(out_req)); // R3

endmodule

// File: tb/hs_avg_filter_tb_top.sv
`timescale 1ns/1ps
module hs_avg_filter_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int W          = 8;
    localparam int WD_CYCLES  = 100000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_req = 1'b0;
    logic [W-1:0] in_data = '0;
    logic         in_ack;
    logic         out_req;
    logic [W-1:0] out_data;
    logic         out_ack = 1'b0;

    int n_tests = 0;
    int n_fail  = 0;
    int cons_delay = 1;
    int y_model = 0;
    int exp_q[$];
    bit out_done = 1'b0;
    bit prev_out_req = 1'b0;
    bit prev_in_ack  = 1'b0;
    logic [W-1:0] held = '0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hs_avg_filter #(.DATA_W(W), .ADD_LAT(2)) dut_i (
        .clk (clk), .rst_n (rst_n), .in_req (in_req), .in_data (in_data),
        .in_ack (in_ack), .out_req (out_req), .out_data (out_data),
        .out_ack (out_ack)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic send(input int x);
        @(posedge clk); #1;
        in_data = W'(x);
        in_req  = 1'b1;
        exp_q.push_back((x + y_model) >> 1);
        y_model = x;
        while (!in_ack) @(posedge clk);
        #1 in_req = 1'b0;
        while (in_ack) @(posedge clk);
    endtask

    // consumer
    initial begin
        forever begin
            while (!out_req) @(posedge clk);
            repeat (cons_delay) @(posedge clk);
            #1 out_ack = 1'b1;
            @(posedge clk);
            while (out_req) @(posedge clk);
            #1 out_ack = 1'b0;
        end
    end

    // per-clock monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (out_req && !prev_out_req) begin
                check(out_ack == 1'b0, "R6 out_ack low at out_req rise", out_ack, 0);
                if (exp_q.size() == 0) begin
                    check(1'b0, "R2 unexpected output", out_data, -1);
                end else begin
                    int e;
                    e = exp_q.pop_front();
                    check(out_data == W'(e), "R2/R3 average value", out_data, e);
                end
                held = out_data;
            end else if (out_req && !out_ack) begin
                if (out_data != held)
                    check(1'b0, "R4 out_data stable", out_data, held);
            end
            if (!out_req && prev_out_req) begin
                check(out_ack == 1'b1, "R6 out_req fell with ack high", out_ack, 1);
                out_done = 1'b1;
            end
            if (in_ack && !prev_in_ack) begin
                check(out_done && !out_req && !out_ack, "R5 in_ack after output return",
                      int'(out_done), 1);
                out_done = 1'b0;
            end
            if (!in_ack && prev_in_ack)
                check(in_req == 1'b0, "R7 in_ack fell after in_req low", in_req, 0);
            prev_out_req = out_req;
            prev_in_ack  = in_ack;
        end
    end

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", WD_CYCLES, 0);
            $display("[TB] %0d tests run, %0d failed", n_tests + 1, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(in_ack == 0 && out_req == 0, "R1 reset handshake outputs", {in_ack, out_req}, 0);
        check(out_data == 0, "R1 reset out_data", out_data, 0);
        @(posedge clk); #1 rst_n = 1'b1;
        @(negedge clk);
        check(in_ack == 0 && out_req == 0 && out_data == 0, "R1 after reset", out_data, 0);

        // R3: first output uses y = 0
        send(100);
        send(20);
        send(0);
        // R8: full-scale operands
        send(255);
        send(255);
        send(254);
        send(1);
        send(0);
        send(255);

        // R5: stalled consumer keeps in_ack low
        cons_delay = 40;
        fork
            send(77);
            begin
                while (!out_req) @(negedge clk);
                repeat (30) @(negedge clk);
                check(in_ack == 0 && out_req == 1, "R5 in_ack low during stall", in_ack, 0);
            end
        join

        // mixed consumer delays
        for (int i = 0; i < 40; i++) begin
            cons_delay = (i * 7) % 5;
            send((i * 53 + 11) % 256);
        end

        repeat (5) @(posedge clk);
        check(exp_q.size() == 0, "R2 all outputs delivered", exp_q.size(), 0);
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule